// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block sits on the device side of a 16-bit memory array. It produces the word address the array reads from. The array can be read in two ways: an ordinary asynchronous read, or a clocked burst read. After reset the block is in asynchronous mode. In that mode it registers the host address whenever chip enable and output enable are both active, and it never raises data-valid.

An upstream command decoder recognises the multi-cycle enable and disable command sequences and passes the result here as single-cycle pulses. Once the enable pulse arrives, the block is in burst mode. In burst mode it captures a starting address on an active-low load strobe. After a fixed latency it presents the first word and holds it until the host pulls the active-low advance strobe. From then on it steps the word address on every clock edge.

The burst is 32 words long. The address wraps inside the aligned 32-word block that holds the start address. An active-low last-word flag marks the final word. Burst mode ends on the disable pulse or the hardware reset. It does not end on the soft reset pulse, which only abandons the burst in flight.

Top module: `burst_read_seq`

## Requirements
- R1: In the first cycle after the synchronous reset: data_valid is 0, last_n is 1, addr_out is 0, and the block is in asynchronous mode.
- R2: In asynchronous mode, while ce_n and oe_n are both 0, addr_out takes the value of addr_in at each rising edge. data_valid stays 0 whatever ld_n does.
- R3: A mode_on pulse enters burst mode. A mode_off pulse or rst leaves it, and the block then returns to following addr_in. In burst mode with no burst running, addr_out does not follow addr_in.
- R4: In burst mode, the address is captured at a rising edge where ld_n is 0, provided ce_n and oe_n are 0. If ld_n is still 0 at the next edge, the address is captured again and the latency starts over.
- R5: data_valid rises INIT_LAT edges after the capturing edge (default 3). At that point addr_out equals the captured address and last_n is 1. data_valid is 0 at the edges in between.
- R6: The first word stays presented for as long as adv_n is 1 at each edge. The first edge that sees adv_n at 0 steps to the next word. After that the address steps on every edge, whatever adv_n does.
- R7: Word k of a burst (counting from 0) has address {start[18:5], (start[4:0]+k) mod 32}. The upper bits never change during a burst.
- R8: last_n is 0 exactly while the 32nd word is presented, whatever the start offset. At the next edge last_n returns to 1, data_valid falls to 0, and the block waits for a new load.
- R9: ce_n or oe_n at 1 at an edge abandons the burst: data_valid goes to 0 and last_n to 1 at that edge. Burst mode is kept.
- R10: A soft_rst pulse abandons the burst in the same way, and burst mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ld_n | input | 1 | Load start address strobe, active low |
| adv_n | input | 1 | Host-ready / advance strobe, active low |
| mode_on | input | 1 | Burst mode enable pulse from the command decoder |
| mode_off | input | 1 | Burst mode disable pulse from the command decoder |
| soft_rst | input | 1 | Soft reset command pulse from the command decoder |
| addr_in | input | 19 | Host word address |
| addr_out | output | 19 | Array word address |
| data_valid | output | 1 | Burst word valid |
| last_n | output | 1 | Last word of burst, active low |

## Verification
The sweep starts one burst at each of the 32 offsets in the block. Each burst uses a different upper address and a different number of first-word hold cycles. This separates correct wrap from carry into the upper bits, and it places the last-word flag on the 32nd word no matter where the wrap falls. During streaming, adv_n is toggled so that a design which still gates on it shows up.

Separate patterns cover the following cases:
- a load strobe held over two edges, which must capture the second address;
- aborts through chip enable, output enable and soft reset, each followed by a clean burst that shows the mode survived;
- the disable pulse and the hardware reset, each of which must restore the asynchronous address-follow behaviour.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAT,
    ST_HOLD,
    ST_STREAM,
    ST_LAST
  } brs_state_e;
endpackage

// File: rtl/brs_mode_reg.sv
module brs_mode_reg (
  input  logic clk,
  input  logic rst,
  input  logic mode_on,
  input  logic mode_off,
  output logic burst_mode
);
  always_ff @(posedge clk) begin
    if (rst || mode_off) burst_mode <= 1'b0;
    else if (mode_on)    burst_mode <= 1'b1;
  end

  // R3: a disable pulse always leaves burst mode
  a_r3_off_clears: assert property (@(posedge clk) disable iff (rst)
    mode_off |=> !burst_mode);
endmodule

// File: rtl/brs_latency.sv
module brs_latency #(
  parameter int INIT_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int LAT_W = (INIT_LAT < 2) ? 1 : $clog2(INIT_LAT);

  logic [LAT_W-1:0] cnt;

  assign expire = run && (cnt == LAT_W'(INIT_LAT - 1));

  always_ff @(posedge clk) begin
    if (rst || start)   cnt <= '0;
    else if (run && !expire) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/brs_addr_gen.sv
module brs_addr_gen #(
  parameter int AW        = 19,
  parameter int BURST_LEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          follow,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);
  localparam int OFS_W = $clog2(BURST_LEN);

  logic [AW-1:OFS_W] base_q;
  logic [OFS_W-1:0]  ofs_q;

  assign addr_out = {base_q, ofs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ofs_q  <= '0;
    end else if (load || follow) begin
      base_q <= addr_in[AW-1:OFS_W];
      ofs_q  <= addr_in[OFS_W-1:0];
    end else if (step) begin
      ofs_q  <= ofs_q + 1'b1;
    end
  end

  // R7: stepping never leaves the aligned block
  a_r7_block_kept: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !follow) |=> $stable(addr_out[AW-1:OFS_W]));
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq
  import brs_pkg::*;
#(
  parameter int AW        = 19,
  parameter int BURST_LEN = 32,
  parameter int INIT_LAT  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          ld_n,
  input  logic          adv_n,
  input  logic          mode_on,
  input  logic          mode_off,
  input  logic          soft_rst,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          data_valid,
  output logic          last_n
);
  localparam int WC_W = $clog2(BURST_LEN + 1);

  brs_state_e      state, nxt;
  logic            burst_mode;
  logic            abort, capture, step, follow, expire, in_lat;
  logic [WC_W-1:0] wcnt;
  logic            final_step;

  brs_mode_reg u_mode (
    .clk(clk), .rst(rst), .mode_on(mode_on), .mode_off(mode_off),
    .burst_mode(burst_mode)
  );

  assign abort      = ce_n || oe_n || soft_rst || mode_off;
  assign capture    = burst_mode && !abort && !ld_n;
  assign in_lat     = (state == ST_LAT) && !abort && !capture;
  assign step       = !abort && !capture &&
                      (((state == ST_HOLD) && !adv_n) || (state == ST_STREAM));
  assign follow     = !burst_mode && !ce_n && !oe_n;
  assign final_step = (wcnt == WC_W'(BURST_LEN - 1));

  brs_latency #(.INIT_LAT(INIT_LAT)) u_lat (
    .clk(clk), .rst(rst), .start(capture), .run(in_lat), .expire(expire)
  );

  brs_addr_gen #(.AW(AW), .BURST_LEN(BURST_LEN)) u_addr (
    .clk(clk), .rst(rst), .load(capture), .step(step), .follow(follow),
    .addr_in(addr_in), .addr_out(addr_out)
  );

  always_comb begin
    nxt = state;
    if (abort || !burst_mode) nxt = ST_IDLE;
    else if (capture)         nxt = ST_LAT;
    else begin
      case (state)
        ST_LAT:    if (expire) nxt = ST_HOLD;
        ST_HOLD:   if (!adv_n) nxt = final_step ? ST_LAST : ST_STREAM;
        ST_STREAM: if (final_step) nxt = ST_LAST;
        ST_LAST:   nxt = ST_IDLE;
        default:   nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wcnt       <= '0;
      data_valid <= 1'b0;
      last_n     <= 1'b1;
    end else begin
      state      <= nxt;
      data_valid <= (nxt == ST_HOLD) || (nxt == ST_STREAM) || (nxt == ST_LAST);
      last_n     <= (nxt != ST_LAST);
      if (capture)                wcnt <= '0;
      else if (in_lat && expire)  wcnt <= WC_W'(1);
      else if (step)              wcnt <= wcnt + 1'b1;
    end
  end

  // R8: the last-word flag lasts one cycle and only with a valid word
  a_r8_last_one_cycle: assert property (@(posedge clk) disable iff (rst)
    !last_n |=> last_n);
  a_r8_last_has_valid: assert property (@(posedge clk) disable iff (rst)
    !last_n |-> data_valid);
  // R9: chip or output enable inactive drops the burst
  a_r9_abort_drops: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n) |=> (!data_valid && last_n));
  // R5: nothing valid while the initial latency runs
  a_r5_lat_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LAT) |-> !data_valid);
  // R6: first word held while the advance strobe is high
  a_r6_hold_addr: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_HOLD) && adv_n && !abort && ld_n) |=>
      ($stable(addr_out) && data_valid));
endmodule

// File: tb/test_burst_read_seq.sv
`timescale 1ns/1ps
module test_burst_read_seq;
  localparam int AW  = 19;
  localparam int LEN = 32;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, ld_n = 1'b1, adv_n = 1'b1;
  logic          mode_on = 1'b0, mode_off = 1'b0, soft_rst = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          data_valid, last_n;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  burst_read_seq #(.AW(AW), .BURST_LEN(LEN), .INIT_LAT(LAT)) i_burst_read_seq (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .ld_n(ld_n), .adv_n(adv_n),
    .mode_on(mode_on), .mode_off(mode_off), .soft_rst(soft_rst),
    .addr_in(addr_in), .addr_out(addr_out), .data_valid(data_valid), .last_n(last_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int k);
    logic [4:0] o;
    o = a[4:0] + 5'(k);
    return {a[AW-1:5], o};
  endfunction

  // capture and deliver the first word
  task automatic start_burst(input logic [AW-1:0] a);
    ld_n = 1'b0; addr_in = a; adv_n = 1'b1;
    step();
    ld_n = 1'b1; addr_in = ~a;
    for (int k = 1; k < LAT; k++) begin
      step();
      chk(data_valid == 1'b0, "R5 no early valid", data_valid, 0);
    end
    step();
    chk(data_valid == 1'b1, "R5 valid after latency", data_valid, 1);
    chk(addr_out == a, "R5 first address", addr_out, a);
    chk(last_n == 1'b1, "R5 last_n high", last_n, 1);
  endtask

  task automatic finish_burst(input logic [AW-1:0] a, input int hold);
    for (int h = 0; h < hold; h++) begin
      adv_n = 1'b1;
      step();
      chk(addr_out == a && data_valid, "R6 first word held", addr_out, a);
    end
    adv_n = 1'b0;
    for (int w = 1; w < LEN; w++) begin
      step();
      chk(addr_out == exp_addr(a, w), "R7 burst address", addr_out, exp_addr(a, w));
      chk(data_valid == 1'b1, "R6 streaming valid", data_valid, 1);
      chk(last_n == (w != LEN - 1), "R8 last flag", last_n, (w != LEN - 1));
      adv_n = w[1];
    end
    adv_n = 1'b1;
    step();
    chk(data_valid == 1'b0 && last_n == 1'b1, "R8 burst end", {data_valid, last_n}, 2'b01);
  endtask

  task automatic stream_some(input logic [AW-1:0] a, input int n);
    adv_n = 1'b0;
    for (int w = 1; w <= n; w++) begin
      step();
      chk(addr_out == exp_addr(a, w), "R6 partial stream", addr_out, exp_addr(a, w));
    end
  endtask

  initial begin
    logic [AW-1:0] a, held;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk(data_valid == 0 && last_n == 1 && addr_out == 0, "R1 reset state",
        {addr_out, data_valid, last_n}, 1);

    // asynchronous mode
    ce_n = 1'b0; oe_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      addr_in = AW'(i * 12345 + 7);
      ld_n = i[0];
      step();
      chk(addr_out == addr_in, "R2 follows addr_in", addr_out, addr_in);
      chk(data_valid == 1'b0, "R2 no valid", data_valid, 0);
    end
    ld_n = 1'b1;

    // enter burst mode
    mode_on = 1'b1; step(); mode_on = 1'b0;
    held = addr_out;
    addr_in = 19'h12345; step();
    chk(addr_out == held, "R3 burst idle no follow", addr_out, held);

    // offset sweep
    for (int o = 0; o < LEN; o++) begin
      a = {AW'(o * 7 + 3)} << 5 | AW'(o);
      start_burst(a);
      finish_burst(a, o % 3);
    end

    // two-edge load strobe recaptures
    ld_n = 1'b0; addr_in = 19'h0AAA1; step();
    addr_in = 19'h3555E;
    start_burst(19'h3555E);
    finish_burst(19'h3555E, 1);
    chk(1'b1, "R4 recapture done", 0, 0);

    // soft reset aborts but keeps the mode
    start_burst(19'h01010);
    stream_some(19'h01010, 4);
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
    chk(data_valid == 0 && last_n == 1, "R10 soft reset abort", data_valid, 0);
    start_burst(19'h7FFFF);
    finish_burst(19'h7FFFF, 0);

    // chip enable abort
    start_burst(19'h00400);
    stream_some(19'h00400, 6);
    ce_n = 1'b1; step(); ce_n = 1'b0;
    chk(data_valid == 0 && last_n == 1, "R9 ce abort", data_valid, 0);
    start_burst(19'h0041F);
    finish_burst(19'h0041F, 2);

    // output enable abort at the last word
    start_burst(19'h22220);
    stream_some(19'h22220, 30);
    oe_n = 1'b1; step(); oe_n = 1'b0;
    chk(data_valid == 0 && last_n == 1, "R9 oe abort", {data_valid, last_n}, 1);
    start_burst(19'h22221);
    finish_burst(19'h22221, 0);

    // disable pulse returns to asynchronous mode
    mode_off = 1'b1; step(); mode_off = 1'b0;
    addr_in = 19'h05A5A; ld_n = 1'b0; step();
    chk(addr_out == 19'h05A5A, "R3 off follows", addr_out, 19'h05A5A);
    ld_n = 1'b1;
    for (int k = 0; k < LAT + 2; k++) begin
      step();
      chk(data_valid == 1'b0, "R3 off no burst", data_valid, 0);
    end

    // hardware reset also leaves burst mode
    mode_on = 1'b1; step(); mode_on = 1'b0;
    start_burst(19'h00100);
    rst = 1'b1; step(); rst = 1'b0;
    chk(data_valid == 0 && addr_out == 0, "R1 reset mid burst", addr_out, 0);
    addr_in = 19'h00777; step();
    chk(addr_out == 19'h00777, "R3 reset follows", addr_out, 19'h00777);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule